// File: doc/BRIEF.md
# Set/Clear Interrupt Status Aggregator

This block holds a 32-bit interrupt pending word that collects completion events from internal units and requests written by software. Software acknowledges pending bits by writing a mask to a clear offset, and can raise any bit pattern through a separate set offset, for example to test an interrupt handler without real hardware activity. The pending word is readable at a status offset.

The block drives one of two interrupt styles, chosen by a mode input. In level mode a single line stays high for as long as any bit is pending. In message mode the block emits a one-cycle request pulse each time a raise happens while something is pending. Sending the message on a bus is left to a neighbouring block that consumes the pulse.

All updates are synchronous. A write, an event or a mode change sampled at a clock edge shows on the status word and on both interrupt outputs right after that edge.

Top module: `irq_aggregator`

## Requirements
- R1: A synchronous active-low reset clears the pending word and drives `irq_level` and `msi_req` low at the first edge where reset is sampled low.
- R2: With `reg_addr` equal to 0x24, `reg_rdata` shows the pending word in the same cycle without a clock edge; at any other address `reg_rdata` is zero.
- R3: A write to offset 0x60 ORs `reg_wdata` into the pending word at that edge; bits that are zero in the mask keep their value.
- R4: A write to offset 0x64 clears every pending bit that is one in `reg_wdata` and keeps all other bits.
- R5: A write to any offset other than 0x60 and 0x64, including the status offset 0x24, leaves the pending word unchanged.
- R6: `hw_evt[0]` (factorial completion) sets pending bit 0 and `hw_evt[1]` (transfer completion) sets pending bit 8 at the edge where it is sampled high.
- R7: When a clear write and a hardware event fall in the same cycle, the event's bit ends up set and the clear applies to the other bits of its mask.
- R8: In level mode (`msg_mode` = 0 at the edge), `irq_level` after the edge is one exactly when the pending word after that edge is nonzero, so it drops only when a clear leaves nothing pending.
- R9: In message mode (`msg_mode` = 1 at the edge), every raise (a write to 0x60 with any mask, including zero, or any high `hw_evt` bit) makes `msi_req` high for the one cycle after that edge if the pending word after the edge is nonzero; consecutive raises give consecutive pulses.
- R10: `msi_req` stays low after an edge with no raise, in particular after a clear write in message mode, and after every edge sampled in level mode.
- R11: `irq_level` is low after every edge where `msg_mode` is sampled as one, even with bits pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_mode | input | 1 | 1 selects message pulses, 0 selects the level line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 32 | Write mask |
| reg_rdata | output | 32 | Pending word at the status offset, zero elsewhere |
| hw_evt | input | 2 | Internal completion events: bit 0 factorial, bit 1 transfer |
| irq_level | output | 1 | Level interrupt line (level mode only) |
| msi_req | output | 1 | One-cycle message request (message mode only) |

## Verification
The collision that matters is a software acknowledge landing in the same cycle as a hardware completion event, since the clear mask and the event can target the same bit. The bench fills the pending word, then applies each event combination together with clear masks that cover the event bits, only some of them, or all bits, and compares the word and the level line against an arithmetic model in which the set takes precedence. In message mode a software raise with an empty mask and a hardware event are also placed next to clears, and every cycle's pulse is judged against whether a raise occurred and whether anything was left pending.

// File: rtl/irq_agg_pkg.sv
// Shared constants for the interrupt status aggregator.
// Assumes a byte-offset register space; offsets fit in the address width.
package irq_agg_pkg;
    localparam int unsigned AGG_DATA_W    = 32;
    localparam int unsigned AGG_ADDR_W    = 8;
    localparam int unsigned AGG_EVT_N     = 2;
    localparam int unsigned AGG_POS_W     = 8;
    localparam int unsigned OFS_STATUS    = 'h24;
    localparam int unsigned OFS_RAISE     = 'h60;
    localparam int unsigned OFS_ACK       = 'h64;

    // Which of the two signalling styles is active in a cycle.
    typedef enum logic {
        SIG_LEVEL   = 1'b0,
        SIG_MESSAGE = 1'b1
    } sig_style_t;
endpackage

// File: rtl/irq_agg_decode.sv
// Register write decoder.
// Turns a write strobe and offset into a set mask, a clear mask and a
// software raise flag. Assumes one write per cycle; reads have no side effect.
module irq_agg_decode #(
    parameter int unsigned ADDR_W    = irq_agg_pkg::AGG_ADDR_W,
    parameter int unsigned DATA_W    = irq_agg_pkg::AGG_DATA_W,
    parameter int unsigned RAISE_OFS = irq_agg_pkg::OFS_RAISE,
    parameter int unsigned ACK_OFS   = irq_agg_pkg::OFS_ACK
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sw_set,
    output logic [DATA_W-1:0] sw_clr,
    output logic              sw_raise
);
    localparam logic [ADDR_W-1:0] RAISE_A = ADDR_W'(RAISE_OFS);
    localparam logic [ADDR_W-1:0] ACK_A   = ADDR_W'(ACK_OFS);

    logic hit_raise;
    logic hit_ack;

    // Match the write offset against the two writable offsets.
    always_comb begin
        hit_raise = wr && (addr == RAISE_A);
        hit_ack   = wr && (addr == ACK_A);
    end

    // Gate the written mask onto the set or clear path.
    always_comb begin
        sw_set   = hit_raise ? wdata : '0;
        sw_clr   = hit_ack   ? wdata : '0;
        sw_raise = hit_raise;
    end
endmodule

// File: rtl/irq_agg_evt_map.sv
// Internal event mapper.
// Places each internal event input on its own pending bit. Bit positions come
// from a packed parameter, one AGG_POS_W-wide field per event; each position
// is assumed to be below DATA_W.
module irq_agg_evt_map #(
    parameter int unsigned DATA_W = irq_agg_pkg::AGG_DATA_W,
    parameter int unsigned EVT_N  = irq_agg_pkg::AGG_EVT_N,
    parameter int unsigned POS_W  = irq_agg_pkg::AGG_POS_W,
    parameter logic [EVT_N*POS_W-1:0] EVT_POS = {8'd8, 8'd0}
) (
    input  logic [EVT_N-1:0]  evt,
    output logic [DATA_W-1:0] hw_set,
    output logic              hw_raise
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] part [EVT_N];

    for (genvar g = 0; g < EVT_N; g++) begin : g_evt
        // One-hot contribution of event g, or nothing when it is idle.
        always_comb begin
            part[g] = evt[g] ? (ONE << EVT_POS[g*POS_W +: POS_W]) : '0;
        end
    end

    // Merge all contributions and flag any active event as a raise.
    always_comb begin
        hw_set = '0;
        for (int i = 0; i < EVT_N; i++) begin
            hw_set = hw_set | part[i];
        end
        hw_raise = |evt;
    end
endmodule

// File: rtl/irq_agg_status.sv
// Pending status register.
// Clears the bits of the clear mask, then ORs in the software and hardware
// set masks, so a set overrides a same-cycle clear of the same bit. Exposes
// both the current word and the value it takes at the next edge.
module irq_agg_status #(
    parameter int unsigned DATA_W = irq_agg_pkg::AGG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sw_set,
    input  logic [DATA_W-1:0] sw_clr,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] status_d
);
    // Next pending word: clear first, sets last.
    always_comb begin
        status_d = (status_q & ~sw_clr) | sw_set | hw_set;
    end

    // Hold the pending word; synchronous reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0));

    assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set != '0) |=> ((status_q & $past(sw_set)) == $past(sw_set)));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr != '0 && sw_set == '0 && hw_set == '0)
        |=> ((status_q & $past(sw_clr)) == '0));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr == '0 && sw_set == '0 && hw_set == '0) |=> $stable(status_q));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((status_q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/irq_agg_notify.sv
// Interrupt output stage.
// Registers the level line and the message pulse from the next pending word,
// the raise flag and the signalling style. Assumes the style input is stable
// in the sense of being sampled like any other input at each edge.
module irq_agg_notify #(
    parameter int unsigned DATA_W = irq_agg_pkg::AGG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irq_agg_pkg::sig_style_t style,
    input  logic              raise,
    input  logic [DATA_W-1:0] status_d,
    input  logic [DATA_W-1:0] status_q,
    output logic              irq_level,
    output logic              msi_req
);
    import irq_agg_pkg::*;

    logic pend_d;
    logic level_d;
    logic pulse_d;

    // Decide both outputs for the coming cycle.
    always_comb begin
        pend_d  = |status_d;
        level_d = (style == SIG_LEVEL) && pend_d;
        pulse_d = (style == SIG_MESSAGE) && raise && pend_d;
    end

    // Register both outputs; reset drives them low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= 1'b0;
            msi_req   <= 1'b0;
        end else begin
            irq_level <= level_d;
            msi_req   <= pulse_d;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_level && !msi_req));

    assert_level_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (style == SIG_LEVEL) |=> (irq_level == (|status_q)));

    assert_pulse_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> (|status_q));

    assert_raise_pulses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (style == SIG_MESSAGE && raise) |=> (msi_req == (|status_q)));

    assert_no_raise_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !raise |=> !msi_req);

    assert_level_mode_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (style == SIG_LEVEL) |=> !msi_req);

    assert_message_line_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (style == SIG_MESSAGE) |=> !irq_level);
endmodule

// File: rtl/irq_aggregator.sv
// Set/clear interrupt status aggregator, top level.
// Collects software raise/acknowledge writes and internal completion events
// into one pending word, exposes it for reading and drives either a level
// line or a one-cycle message request. Assumes a single-beat register port
// with at most one write per cycle.
module irq_aggregator #(
    parameter int unsigned ADDR_W     = irq_agg_pkg::AGG_ADDR_W,
    parameter int unsigned DATA_W     = irq_agg_pkg::AGG_DATA_W,
    parameter int unsigned EVT_N      = irq_agg_pkg::AGG_EVT_N,
    parameter int unsigned STATUS_OFS = irq_agg_pkg::OFS_STATUS,
    parameter int unsigned RAISE_OFS  = irq_agg_pkg::OFS_RAISE,
    parameter int unsigned ACK_OFS    = irq_agg_pkg::OFS_ACK,
    parameter logic [EVT_N*irq_agg_pkg::AGG_POS_W-1:0] EVT_POS = {8'd8, 8'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_mode,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_N-1:0]  hw_evt,
    output logic              irq_level,
    output logic              msi_req
);
    import irq_agg_pkg::*;

    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);

    logic [DATA_W-1:0] sw_set;
    logic [DATA_W-1:0] sw_clr;
    logic [DATA_W-1:0] hw_set;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] status_d;
    logic              sw_raise;
    logic              hw_raise;
    logic              any_raise;
    sig_style_t        style;

    irq_agg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .RAISE_OFS(RAISE_OFS), .ACK_OFS(ACK_OFS)
    ) u_decode (
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .sw_set(sw_set), .sw_clr(sw_clr), .sw_raise(sw_raise)
    );

    irq_agg_evt_map #(
        .DATA_W(DATA_W), .EVT_N(EVT_N),
        .POS_W(AGG_POS_W), .EVT_POS(EVT_POS)
    ) u_evt_map (
        .evt(hw_evt), .hw_set(hw_set), .hw_raise(hw_raise)
    );

    irq_agg_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .sw_set(sw_set), .sw_clr(sw_clr), .hw_set(hw_set),
        .status_q(status_q), .status_d(status_d)
    );

    // Combine raise sources and translate the mode pin into a style.
    always_comb begin
        any_raise = sw_raise || hw_raise;
        style     = msg_mode ? SIG_MESSAGE : SIG_LEVEL;
    end

    irq_agg_notify #(.DATA_W(DATA_W)) u_notify (
        .clk(clk), .rst_n(rst_n), .style(style), .raise(any_raise),
        .status_d(status_d), .status_q(status_q),
        .irq_level(irq_level), .msi_req(msi_req)
    );

    // Read port: the pending word at its offset, zero elsewhere.
    always_comb begin
        reg_rdata = (reg_addr == STATUS_A) ? status_q : '0;
    end
endmodule

// File: tb/irq_aggregator_bench.sv
// Self-checking bench for irq_aggregator with an arithmetic pending-word model.
module irq_aggregator_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h24;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  hw_evt = '0;
    logic        irq_level;
    logic        msi_req;

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] exp_status = '0;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hw_evt(hw_evt),
        .irq_level(irq_level), .msi_req(msi_req)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: apply inputs after a falling edge, predict, sample after the next falling edge.
    task automatic cyc(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                       input logic [1:0] ev, input logic mode, input string tag);
        logic [31:0] setm, clrm, hwm, nxt;
        logic        rse, e_lvl, e_msi;
        reg_wr = wr; reg_addr = addr; reg_wdata = data; hw_evt = ev; msg_mode = mode;
        hwm  = {23'b0, ev[1], 7'b0, ev[0]};
        setm = (wr && addr == 8'h60) ? data : 32'h0;
        clrm = (wr && addr == 8'h64) ? data : 32'h0;
        rse  = (wr && addr == 8'h60) || (ev != 2'b00);
        nxt  = (exp_status & ~clrm) | setm | hwm;
        e_lvl = !mode && (nxt != 0);
        e_msi = mode && rse && (nxt != 0);
        @(posedge clk);
        @(negedge clk);
        exp_status = nxt;
        reg_wr = 1'b0; hw_evt = 2'b00; reg_addr = 8'h24; reg_wdata = '0;
        #1;
        chk(reg_rdata == exp_status, {tag, " status"}, reg_rdata, exp_status);
        chk(irq_level == e_lvl, {tag, " irq_level"}, 32'(irq_level), 32'(e_lvl));
        chk(msi_req == e_msi, {tag, " msi_req"}, 32'(msi_req), 32'(e_msi));
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_status = '0;
        reg_addr = 8'h24;
        #1;
        chk(reg_rdata == 32'h0, {tag, " status"}, reg_rdata, 32'h0);
        chk(irq_level == 1'b0, {tag, " irq_level"}, 32'(irq_level), 32'h0);
        chk(msi_req == 1'b0, {tag, " msi_req"}, 32'(msi_req), 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        do_reset("R1 power-up");

        // Walking-one raises and acknowledges in level mode.
        for (int i = 0; i < 32; i++) cyc(1'b1, 8'h60, 32'h1 << i, 2'b00, 1'b0, "R3/R8 walk set");
        for (int i = 0; i < 32; i++) cyc(1'b1, 8'h64, 32'h1 << i, 2'b00, 1'b0, "R4/R8 walk clear");

        // Multi-bit masks keep the untouched bits.
        cyc(1'b1, 8'h60, 32'hA5A5_0F0F, 2'b00, 1'b0, "R3 mask set");
        cyc(1'b1, 8'h60, 32'h0000_F000, 2'b00, 1'b0, "R3 mask or");
        cyc(1'b1, 8'h64, 32'h0F0F_FFFF, 2'b00, 1'b0, "R4 partial clear");

        // Read of another offset returns zero.
        reg_addr = 8'h28; #1;
        chk(reg_rdata == 32'h0, "R2 other offset read", reg_rdata, 32'h0);
        reg_addr = 8'h24; #1;
        chk(reg_rdata == exp_status, "R2 status read", reg_rdata, exp_status);

        // Writes to other offsets change nothing.
        cyc(1'b1, 8'h24, 32'hFFFF_FFFF, 2'b00, 1'b0, "R5 write status offset");
        cyc(1'b1, 8'h20, 32'h0000_0000, 2'b00, 1'b0, "R5 write 0x20");
        cyc(1'b1, 8'h61, 32'hFFFF_FFFF, 2'b00, 1'b0, "R5 write 0x61");
        cyc(1'b1, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b0, "R4 clear all");

        // Each event combination from an empty word.
        for (int e = 1; e < 4; e++) begin
            cyc(1'b0, 8'h24, 32'h0, 2'(e), 1'b0, "R6 event set");
            cyc(1'b1, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b0, "R8 line drops");
        end

        // Clear and event in the same cycle, sweeping events and masks.
        for (int e = 1; e < 4; e++) begin
            for (int m = 0; m < 4; m++) begin
                logic [31:0] cm;
                cm = (m == 0) ? 32'hFFFF_FFFF : (m == 1) ? 32'h0000_0101 :
                     (m == 2) ? 32'h0000_0100 : 32'h0000_0001;
                cyc(1'b1, 8'h60, 32'hFFFF_FFFF, 2'b00, 1'b0, "R3 refill");
                cyc(1'b1, 8'h64, cm, 2'(e), 1'b0, "R7 clear vs event");
            end
        end

        // Message mode.
        cyc(1'b0, 8'h24, 32'h0, 2'b00, 1'b1, "R11 mode switch pending");
        cyc(1'b1, 8'h60, 32'h0, 2'b00, 1'b1, "R9 zero-mask raise pending");
        cyc(1'b1, 8'h60, 32'h0, 2'b00, 1'b1, "R9 back-to-back raise");
        cyc(1'b1, 8'h64, 32'h0000_00FF, 2'b00, 1'b1, "R10 partial clear silent");
        cyc(1'b1, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b1, "R10 full clear silent");
        cyc(1'b1, 8'h60, 32'h0, 2'b00, 1'b1, "R9 zero-mask raise empty");
        for (int e = 1; e < 4; e++) begin
            cyc(1'b0, 8'h24, 32'h0, 2'(e), 1'b1, "R9 event pulse");
            cyc(1'b1, 8'h64, 32'h0000_0101, 2'(e), 1'b1, "R9/R7 event beats clear");
            cyc(1'b1, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b1, "R10 ack silent");
        end
        for (int i = 0; i < 32; i++) cyc(1'b1, 8'h60, 32'h1 << i, 2'b00, 1'b1, "R9/R11 walk raise");
        cyc(1'b0, 8'h24, 32'h0, 2'b00, 1'b1, "R10 idle no pulse");

        // Back to level mode with bits pending, then an event in level mode.
        cyc(1'b0, 8'h24, 32'h0, 2'b00, 1'b0, "R8 line returns");
        cyc(1'b0, 8'h24, 32'h0, 2'b11, 1'b0, "R10 no pulse in level mode");

        // Reset with state pending.
        do_reset("R1 mid-run");
        cyc(1'b0, 8'h24, 32'h0, 2'b00, 1'b0, "R1 stays empty");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule